// File: doc/BRIEF.md
# Job Ring Credit Counter Unit

This block holds the hardware side of a pair of work rings shared with software: an input ring of job slots and an output ring of result slots. Software sets each ring's size and then moves the rings by writing counts. A jobs-added count uses up input room. A jobs-removed count frees output slots. A processing engine sends one strobe per job it fetches and one strobe per result it posts. From these the block keeps four values: the room left in the input ring, the number of full output slots, the index of the next input slot to read and the index of the next output slot to write.

Every post raises a completion interrupt. When a count is more than a ring can give, the block rejects it and records a typed error code. A command write restarts both rings. The status word then reports a two-step halt: in progress for one cycle, then complete. Any count write made during the in-progress cycle is refused with its own error code. The block moves no descriptor data itself.

Top module: `jr_credit_ring`

## Requirements
- R1: After reset every output is zero: room, full count, both indices, the status word and irq.
- R2: Writes with wr_sel=0 (input size) and wr_sel=1 (output size) keep only wr_data[9:0]. A new size takes effect at the next ring restart, which loads the input room with the input size. wr_sel values 6 and 7 do nothing.
- R3: A jobs-added write (wr_sel=2) whose count is no more than the current input room lowers the room by that count in the next cycle.
- R4: A jobs-added count greater than the current room leaves the room unchanged. It sets status bit 1 and error type 9 in status bits 11:8.
- R5: A jobs-removed write (wr_sel=3) whose count is no more than the current full count lowers the full count by that count.
- R6: A jobs-removed count greater than the full count leaves the full count unchanged. It sets status bit 1 and error type 8.
- R7: A fetch strobe moves the input read index to the next slot, wrapping to 0 when the ring size is reached, and adds one to the room. The strobe is ignored when the room already equals the input size.
- R8: A post strobe moves the output write index to the next slot, wrapping at the output size, adds one to the full count and sets status bit 0. The strobe is ignored when the full count equals the output size.
- R9: A command write (wr_sel=4) with wr_data[0]=1 clears both indices and the full count and loads the room with the input size. Status bits 3:2 read 1 (halt in progress) for one cycle and then 2 (halt complete). A command write with bit 0 clear has no effect.
- R10: During the halt-in-progress cycle, jobs-added and jobs-removed writes change nothing and set status bit 1 with error type 7. Fetch and post strobes are ignored in that cycle.
- R11: A status-clear write (wr_sel=5) clears status bit 0 where wr_data[0]=1 and clears bit 1 together with the error type where wr_data[1]=1. It returns halt complete to 0 where wr_data[3]=1. An event that sets a bit in the same cycle takes priority over the clear.
- R12: A software count and an engine strobe on the same ring in the same cycle combine: the new level is the old level minus the count plus one. When both error codes could apply, 9 takes priority over 8, which takes priority over 7.
- R13: irq is high exactly when status bit 0 or bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Write target: 0 input size, 1 output size, 2 jobs added, 3 jobs removed, 4 command, 5 status clear |
| wr_data | input | DATA_W | Write data |
| fetch_stb | input | 1 | Engine has taken one input job |
| post_stb | input | 1 | Engine has written one result |
| in_room | output | IDX_W | Input slots free for software |
| in_rd_idx | output | IDX_W | Next input slot the engine reads |
| out_full | output | IDX_W | Output slots holding results |
| out_wr_idx | output | IDX_W | Next output slot the engine writes |
| int_stat | output | DATA_W | Status: bit0 done, bit1 error, bits3:2 halt, bits11:8 error type |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the single halt-in-progress cycle, because it exists only for the one clock after a restart command. The stimulus issues the restart and, on the very next cycle, drives a count write together with a fetch strobe. It then checks that the type-7 error is set and that the index did not move. Ring-full and ring-empty edges are reached with small sizes (five input slots, four output slots), so that index wraps and ignored strobes happen within a few cycles. A long random phase mixes size changes, restarts and oversized counts against the reference model.

// File: rtl/jr_credit_pkg.sv
package jr_credit_pkg;

  typedef enum logic [2:0] {
    SEL_IN_SIZE  = 3'd0,
    SEL_OUT_SIZE = 3'd1,
    SEL_ADD      = 3'd2,
    SEL_RMV      = 3'd3,
    SEL_CMD      = 3'd4,
    SEL_ICLR     = 3'd5,
    SEL_NONE6    = 3'd6,
    SEL_NONE7    = 3'd7
  } wsel_e;

  typedef enum logic [1:0] {
    HALT_IDLE = 2'd0,
    HALT_BUSY = 2'd1,
    HALT_DONE = 2'd2
  } halt_e;

  localparam logic [3:0] ETYPE_RESET   = 4'd7;
  localparam logic [3:0] ETYPE_RMV_OVF = 4'd8;
  localparam logic [3:0] ETYPE_ADD_OVF = 4'd9;

  // status word bit positions
  localparam int ST_INT_BIT  = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int ST_HALT_LO  = 2;
  localparam int ST_ETYPE_LO = 8;

endpackage

// File: rtl/jr_ring_ctr.sv
// One ring: a level lowered by software counts and raised by engine strobes,
// plus a wrapping slot index advanced by each accepted strobe.
module jr_ring_ctr #(
  parameter int IDX_W       = 10,
  parameter int DATA_W      = 32,
  parameter bit RST_TO_SIZE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  size,
  input  logic              ring_rst,
  input  logic              halt_busy,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_cnt,
  input  logic              hw_stb,
  output logic [IDX_W-1:0]  level,
  output logic [IDX_W-1:0]  idx,
  output logic              hw_ok,
  output logic              sw_ovf
);

  localparam int PAD_W = DATA_W - IDX_W;

  function automatic logic [IDX_W-1:0] slot_next(input logic [IDX_W-1:0] cur,
                                                  input logic [IDX_W-1:0] lim);
    logic [IDX_W-1:0] nxt;
    nxt = cur + 1'b1;
    return (nxt == lim) ? '0 : nxt;
  endfunction

  function automatic logic [IDX_W-1:0] level_next(input logic [IDX_W-1:0] lvl,
                                                   input logic [IDX_W-1:0] take,
                                                   input logic             give);
    return lvl - take + {{(IDX_W-1){1'b0}}, give};
  endfunction

  logic             sw_req;
  logic [IDX_W-1:0] sw_take;
  logic [IDX_W-1:0] level_d;
  logic [IDX_W-1:0] level_rst;

  generate
    if (RST_TO_SIZE) begin : g_rst_full
      assign level_rst = size;
    end else begin : g_rst_empty
      assign level_rst = '0;
    end
  endgenerate

  assign hw_ok   = hw_stb && !ring_rst && !halt_busy && (level != size);
  assign sw_req  = sw_we && !ring_rst && !halt_busy;
  assign sw_ovf  = sw_req && (sw_cnt > {{PAD_W{1'b0}}, level});
  assign sw_take = (sw_req && !sw_ovf) ? sw_cnt[IDX_W-1:0] : '0;
  assign level_d = level_next(level, sw_take, hw_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      idx   <= '0;
    end else if (ring_rst) begin
      level <= level_rst;
      idx   <= '0;
    end else begin
      level <= level_d;
      if (hw_ok) idx <= slot_next(idx, size);
    end
  end

endmodule

// File: rtl/jr_int_status.sv
// Interrupt, error type and halt tracking for the ring pair.
module jr_int_status
  import jr_credit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_rst,
  input  logic              post_ok,
  input  logic              add_ovf,
  input  logic              rmv_ovf,
  input  logic              busy_rej,
  input  logic              clr_we,
  input  logic              clr_int,
  input  logic              clr_err,
  input  logic              clr_halt,
  output logic [DATA_W-1:0] stat,
  output logic              halt_busy,
  output logic              irq
);

  logic       int_q;
  logic       err_q;
  logic [3:0] etype_q;
  halt_e      halt_q;
  logic       err_set;
  logic [3:0] etype_new;

  function automatic logic [3:0] pick_etype(input logic a_ovf, input logic r_ovf);
    if (a_ovf)      return ETYPE_ADD_OVF;
    else if (r_ovf) return ETYPE_RMV_OVF;
    else            return ETYPE_RESET;
  endfunction

  assign err_set   = add_ovf || rmv_ovf || busy_rej;
  assign etype_new = pick_etype(add_ovf, rmv_ovf);
  assign halt_busy = (halt_q == HALT_BUSY);
  assign irq       = int_q || err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q   <= 1'b0;
      err_q   <= 1'b0;
      etype_q <= '0;
      halt_q  <= HALT_IDLE;
    end else begin
      if (post_ok)                     int_q <= 1'b1;
      else if (clr_we && clr_int)      int_q <= 1'b0;

      if (err_set) begin
        err_q   <= 1'b1;
        etype_q <= etype_new;
      end else if (clr_we && clr_err) begin
        err_q   <= 1'b0;
        etype_q <= '0;
      end

      if (ring_rst)                    halt_q <= HALT_BUSY;
      else if (halt_q == HALT_BUSY)    halt_q <= HALT_DONE;
      else if (halt_q == HALT_DONE && clr_we && clr_halt) halt_q <= HALT_IDLE;
    end
  end

  always_comb begin
    stat = '0;
    stat[ST_INT_BIT]                 = int_q;
    stat[ST_ERR_BIT]                 = err_q;
    stat[ST_HALT_LO +: 2]            = halt_q;
    stat[ST_ETYPE_LO +: 4]           = etype_q;
  end

endmodule

// File: rtl/jr_credit_ring.sv
// Top: write decode, ring sizes, two ring counters and the status block.
module jr_credit_ring
  import jr_credit_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_stb,
  input  logic              post_stb,
  output logic [IDX_W-1:0]  in_room,
  output logic [IDX_W-1:0]  in_rd_idx,
  output logic [IDX_W-1:0]  out_full,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic [DATA_W-1:0] int_stat,
  output logic              irq
);

  wsel_e            sel;
  logic             add_we;
  logic             rmv_we;
  logic             clr_we;
  logic             ring_rst;
  logic             halt_busy;
  logic             busy_rej;
  logic             fetch_ok;
  logic             post_ok;
  logic             add_ovf;
  logic             rmv_ovf;
  logic [IDX_W-1:0] in_size_q;
  logic [IDX_W-1:0] out_size_q;

  assign sel      = wsel_e'(wr_sel);
  assign add_we   = wr_en && (sel == SEL_ADD);
  assign rmv_we   = wr_en && (sel == SEL_RMV);
  assign clr_we   = wr_en && (sel == SEL_ICLR);
  assign ring_rst = wr_en && (sel == SEL_CMD) && wr_data[0];
  assign busy_rej = (add_we || rmv_we) && halt_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_size_q  <= '0;
      out_size_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_IN_SIZE)  in_size_q  <= wr_data[IDX_W-1:0];
      if (sel == SEL_OUT_SIZE) out_size_q <= wr_data[IDX_W-1:0];
    end
  end

  jr_ring_ctr #(.IDX_W(IDX_W), .DATA_W(DATA_W), .RST_TO_SIZE(1'b1)) in_ring_i (
    .clk(clk), .rst_n(rst_n), .size(in_size_q), .ring_rst(ring_rst),
    .halt_busy(halt_busy), .sw_we(add_we), .sw_cnt(wr_data), .hw_stb(fetch_stb),
    .level(in_room), .idx(in_rd_idx), .hw_ok(fetch_ok), .sw_ovf(add_ovf)
  );

  jr_ring_ctr #(.IDX_W(IDX_W), .DATA_W(DATA_W), .RST_TO_SIZE(1'b0)) out_ring_i (
    .clk(clk), .rst_n(rst_n), .size(out_size_q), .ring_rst(ring_rst),
    .halt_busy(halt_busy), .sw_we(rmv_we), .sw_cnt(wr_data), .hw_stb(post_stb),
    .level(out_full), .idx(out_wr_idx), .hw_ok(post_ok), .sw_ovf(rmv_ovf)
  );

  jr_int_status #(.DATA_W(DATA_W)) status_i (
    .clk(clk), .rst_n(rst_n), .ring_rst(ring_rst), .post_ok(post_ok),
    .add_ovf(add_ovf), .rmv_ovf(rmv_ovf), .busy_rej(busy_rej),
    .clr_we(clr_we), .clr_int(wr_data[0]), .clr_err(wr_data[1]), .clr_halt(wr_data[3]),
    .stat(int_stat), .halt_busy(halt_busy), .irq(irq)
  );

endmodule

// File: rtl/jr_credit_ring_chk.sv
module jr_credit_ring_chk #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  in_room,
  input logic [IDX_W-1:0]  in_rd_idx,
  input logic [IDX_W-1:0]  out_full,
  input logic [IDX_W-1:0]  out_wr_idx,
  input logic [DATA_W-1:0] int_stat,
  input logic              fetch_ok,
  input logic              post_ok,
  input logic              add_ovf,
  input logic              rmv_ovf,
  input logic              ring_rst,
  input logic              halt_busy
);

  a_r4_add_ovf_room_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (add_ovf && !fetch_ok) |=> (in_room == $past(in_room)));

  a_r4_add_ovf_code: assert property (@(posedge clk) disable iff (!rst_n)
    add_ovf |=> (int_stat[1] && int_stat[11:8] == 4'd9));

  a_r6_rmv_ovf_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rmv_ovf && !add_ovf) |=> (int_stat[1] && int_stat[11:8] == 4'd8));

  a_r8_post_sets_int: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok |=> int_stat[0]);

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ring_rst |=> (int_stat[3:2] == 2'd1 && out_full == '0 &&
                  in_rd_idx == '0 && out_wr_idx == '0));

  a_r9_halt_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (int_stat[3:2] == 2'd1 && !ring_rst) |=> (int_stat[3:2] == 2'd2));

  a_r10_busy_freezes_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_busy && !ring_rst) |=> ($stable(in_rd_idx) && $stable(out_wr_idx)));

endmodule

bind jr_credit_ring jr_credit_ring_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_room(in_room), .in_rd_idx(in_rd_idx),
  .out_full(out_full), .out_wr_idx(out_wr_idx), .int_stat(int_stat),
  .fetch_ok(fetch_ok), .post_ok(post_ok), .add_ovf(add_ovf), .rmv_ovf(rmv_ovf),
  .ring_rst(ring_rst), .halt_busy(halt_busy)
);

// File: tb/jr_credit_ring_tb_top.sv
`timescale 1ns/1ps
module jr_credit_ring_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        fetch_stb = 1'b0;
  logic        post_stb = 1'b0;
  logic [9:0]  in_room, in_rd_idx, out_full, out_wr_idx;
  logic [31:0] int_stat;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  // reference model state
  int m_isize = 0, m_osize = 0, m_room = 0, m_full = 0, m_ridx = 0, m_widx = 0;
  int m_int = 0, m_err = 0, m_type = 0, m_halt = 0;

  always #2.5 clk = ~clk;

  jr_credit_ring dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fetch_stb(fetch_stb), .post_stb(post_stb), .in_room(in_room),
    .in_rd_idx(in_rd_idx), .out_full(out_full), .out_wr_idx(out_wr_idx),
    .int_stat(int_stat), .irq(irq)
  );

  function automatic int wrap1(input int i, input int lim);
    int n = (i + 1) % 1024;
    return (n == lim) ? 0 : n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_isize = 0; m_osize = 0; m_room = 0; m_full = 0; m_ridx = 0; m_widx = 0;
      m_int = 0; m_err = 0; m_type = 0; m_halt = 0;
    end else begin
      bit busy, restart, f_ok, p_ok, a_req, r_req, a_ovf, r_ovf, rej, clr;
      int d;
      d       = int'(wr_data & 32'h3FF);
      busy    = (m_halt == 1);
      restart = wr_en && wr_sel == 3'd4 && wr_data[0];
      clr     = wr_en && wr_sel == 3'd5;
      if (restart) begin
        m_room = m_isize; m_full = 0; m_ridx = 0; m_widx = 0; m_halt = 1;
      end else begin
        f_ok  = fetch_stb && !busy && (m_room != m_isize);
        p_ok  = post_stb && !busy && (m_full != m_osize);
        a_req = wr_en && wr_sel == 3'd2 && !busy;
        r_req = wr_en && wr_sel == 3'd3 && !busy;
        a_ovf = a_req && (wr_data > 32'(m_room));
        r_ovf = r_req && (wr_data > 32'(m_full));
        rej   = wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3) && busy;
        if (a_req && !a_ovf) m_room -= d;
        if (r_req && !r_ovf) m_full -= d;
        if (f_ok) begin m_room += 1; m_ridx = wrap1(m_ridx, m_isize); end
        if (p_ok) begin m_full += 1; m_widx = wrap1(m_widx, m_osize); end
        if (p_ok) m_int = 1;
        else if (clr && wr_data[0]) m_int = 0;
        if (a_ovf)      begin m_err = 1; m_type = 9; end
        else if (r_ovf) begin m_err = 1; m_type = 8; end
        else if (rej)   begin m_err = 1; m_type = 7; end
        else if (clr && wr_data[1]) begin m_err = 0; m_type = 0; end
        if (m_halt == 1) m_halt = 2;
        else if (m_halt == 2 && clr && wr_data[3]) m_halt = 0;
        if (wr_en && wr_sel == 3'd0) m_isize = d;
        if (wr_en && wr_sel == 3'd1) m_osize = d;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 in_room", int'(in_room), m_room);
      chk("R5 out_full", int'(out_full), m_full);
      chk("R7 in_rd_idx", int'(in_rd_idx), m_ridx);
      chk("R8 out_wr_idx", int'(out_wr_idx), m_widx);
      chk("R11 int_stat", int'(int_stat),
          m_int | (m_err << 1) | (m_halt << 2) | (m_type << 8));
      chk("R13 irq", int'(irq), (m_int | m_err) != 0 ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input logic we, input logic [2:0] s, input logic [31:0] d,
                     input logic f, input logic p);
    wr_en = we; wr_sel = s; wr_data = d; fetch_stb = f; post_stb = p;
    @(negedge clk);
    wr_en = 1'b0; fetch_stb = 1'b0; post_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 room", int'(in_room), 0);
    chk("R1 stat", int'(int_stat), 0);
    chk("R1 irq", int'(irq), 0);
    // R2 sizes from low 10 bits, loaded by restart
    cyc(1, 3'd0, 32'h405, 0, 0);
    cyc(1, 3'd1, 32'hC04, 0, 0);
    cyc(1, 3'd6, 32'h1, 0, 0);
    cyc(1, 3'd4, 32'h1, 0, 0);
    chk("R2 room after restart", int'(in_room), 5);
    chk("R9 halt busy", int'(int_stat), 32'h4);
    cyc(0, 3'd0, 0, 0, 0);
    chk("R9 halt done", int'(int_stat), 32'h8);
    // R3 / R7
    cyc(1, 3'd2, 32'd3, 0, 0);
    chk("R3 room", int'(in_room), 2);
    for (int i = 0; i < 4; i++) cyc(0, 3'd0, 0, 1, 0);
    chk("R7 fetch ignored on empty ring", int'(in_room), 5);
    chk("R7 idx", int'(in_rd_idx), 3);
    cyc(1, 3'd2, 32'd5, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 3'd0, 0, 1, 0);
    chk("R7 wrap", int'(in_rd_idx), 1);
    // R4
    cyc(1, 3'd2, 32'd9, 0, 0);
    chk("R4 room kept", int'(in_room), 3);
    chk("R4 stat", int'(int_stat), 32'h90A);
    // R8
    for (int i = 0; i < 5; i++) cyc(0, 3'd0, 0, 0, 1);
    chk("R8 full", int'(out_full), 4);
    chk("R8 wr idx wrap", int'(out_wr_idx), 0);
    chk("R13 irq", int'(irq), 1);
    // R6
    cyc(1, 3'd3, 32'd6, 0, 0);
    chk("R6 full kept", int'(out_full), 4);
    chk("R6 stat", int'(int_stat), 32'h80B);
    // R12 combined
    cyc(1, 3'd3, 32'd2, 0, 1);
    chk("R12 post blocked at full", int'(out_full), 2);
    cyc(1, 3'd3, 32'd1, 0, 1);
    chk("R12 rmv+post", int'(out_full), 2);
    chk("R12 wr idx", int'(out_wr_idx), 1);
    cyc(1, 3'd2, 32'd2, 1, 0);
    chk("R12 add+fetch", int'(in_room), 2);
    // R11
    cyc(1, 3'd5, 32'hB, 0, 0);
    chk("R11 cleared", int'(int_stat), 0);
    chk("R13 irq low", int'(irq), 0);
    // R9 command without bit 0
    cyc(1, 3'd4, 32'h2, 0, 0);
    chk("R9 no restart", int'(in_room), 2);
    // R10
    cyc(1, 3'd4, 32'h1, 0, 0);
    cyc(1, 3'd2, 32'd1, 1, 0);
    chk("R10 stat", int'(int_stat), 32'h70A);
    chk("R10 room", int'(in_room), 5);
    chk("R10 idx", int'(in_rd_idx), 0);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 9);
      logic [2:0] s = 3'($urandom_range(0, 7));
      logic [31:0] d = (s == 3'd4) ? 32'($urandom_range(0, 1) & ($urandom_range(0, 9) == 0))
                                   : 32'($urandom_range(0, 9));
      cyc(r < 5, s, d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule